// File: doc/BRIEF.md
# Processor Status Flag Register

This block keeps the status flags of a small processor core: carry, parity, auxiliary carry, zero, sign and overflow, and the interrupt enable. Each cycle it takes a 3-bit operation code, an 8-bit byte from the high half of the accumulator, and a six-flag update from the ALU that has one write enable per flag. All changes take effect on the rising clock edge. The flags are then visible on `flags_o` in the next cycle.

The operation code handles the flag-control operations: clear, set and invert carry, and clear and set interrupt enable. It also handles the two byte transfers. Copying the flags out to the byte changes nothing. Writing the byte into the flags replaces only the five low status flags.

The packed status byte on `status_byte` always shows the current flags. Sign is at bit 7, zero at bit 6, auxiliary carry at bit 4, parity at bit 2 and carry at bit 0. The store operation reads the same positions from `byte_in`. Instruction decode and memory are outside this block.

Top module: `flag_reg`

## Requirements
- R1: An asserted active-low reset clears all seven flags, so `flags_o` reads 0 and `status_byte` reads 0x02.
- R2: Op code 1 clears carry, op code 2 sets carry, and op code 3 inverts carry. Each change is visible after the next rising edge.
- R3: Op code 4 clears and op code 5 sets the interrupt enable (`flags_o[6]`). No other op code and no ALU input changes it.
- R4: `flags_o` is laid out as {IE, OF, SF, ZF, AF, PF, CF}, from bit 6 down to bit 0. `status_byte` is {SF, ZF, 0, AF, 0, PF, 1, CF}, from bit 7 down to bit 0.
- R5: Op code 6 copies the flags out to the byte and changes no flag.
- R6: Op code 7 loads SF, ZF, AF, PF and CF from `byte_in` bits 7, 6, 4, 2 and 0. `byte_in` bits 1, 3 and 5 are ignored, and OF and IE are kept. For example, byte 0x1E gives SF=0, ZF=0, AF=1, PF=1 and CF=0.
- R7: The ALU update writes each flag whose enable bit is set in `alu_we`. The bits of `alu_we` and `alu_flags` are {OF, SF, ZF, AF, PF, CF}, from bit 5 down to bit 0. Flags whose enable is low keep their value.
- R8: When an op code and an enabled ALU update target the same flag in one cycle, the op code's value wins. ALU updates to other flags in that same cycle still take effect.
- R9: Op code 0 does nothing. With no ALU enable set, every flag holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 3 | Flag operation code |
| byte_in | input | 8 | Accumulator-high byte for the store operation |
| alu_flags | input | 6 | ALU flag values {OF,SF,ZF,AF,PF,CF} |
| alu_we | input | 6 | Per-flag write enables for `alu_flags` |
| flags_o | output | 7 | Current flags {IE,OF,SF,ZF,AF,PF,CF} |
| status_byte | output | 8 | Packed status byte |

## Verification
The op code and the ALU update can both reach the same flag in one cycle. The bench provokes this by issuing carry-clear, carry-invert and byte-store operations while the ALU enables drive the opposite values onto carry and the other low flags. It also enables OF in the same cycle. A correct result shows the op code's value on every flag the op code targets, and the ALU value on OF.

// File: rtl/flag_reg.sv
module flag_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] op,
  input  logic [7:0] byte_in,
  input  logic [5:0] alu_flags,
  input  logic [5:0] alu_we,
  output logic [6:0] flags_o,
  output logic [7:0] status_byte
);
  localparam logic [2:0] OP_NOP   = 3'd0;
  localparam logic [2:0] OP_CLR_C = 3'd1;
  localparam logic [2:0] OP_SET_C = 3'd2;
  localparam logic [2:0] OP_INV_C = 3'd3;
  localparam logic [2:0] OP_CLR_I = 3'd4;
  localparam logic [2:0] OP_SET_I = 3'd5;
  localparam logic [2:0] OP_LOAD  = 3'd6;
  localparam logic [2:0] OP_STORE = 3'd7;

  localparam int CF = 0, PF = 1, AF = 2, ZF = 3, SF = 4, IE = 6;

  logic [6:0] flg, nxt;

  always_comb begin
    nxt = flg;
    for (int i = 0; i < 6; i++)
      if (alu_we[i]) nxt[i] = alu_flags[i];
    case (op)
      OP_CLR_C: nxt[CF] = 1'b0;
      OP_SET_C: nxt[CF] = 1'b1;
      OP_INV_C: nxt[CF] = ~flg[CF];
      OP_CLR_I: nxt[IE] = 1'b0;
      OP_SET_I: nxt[IE] = 1'b1;
      OP_STORE: begin
        nxt[CF] = byte_in[0];
        nxt[PF] = byte_in[2];
        nxt[AF] = byte_in[4];
        nxt[ZF] = byte_in[6];
        nxt[SF] = byte_in[7];
      end
      OP_NOP, OP_LOAD: ;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flg <= '0;
    else        flg <= nxt;

  assign flags_o     = flg;
  assign status_byte = {flg[SF], flg[ZF], 1'b0, flg[AF], 1'b0, flg[PF], 1'b1, flg[CF]};
endmodule

// File: rtl/flag_reg_chk.sv
module flag_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] op,
  input logic [7:0] byte_in,
  input logic [5:0] alu_flags,
  input logic [5:0] alu_we,
  input logic [6:0] flags_o,
  input logic [7:0] status_byte
);
  AST_CLR_CARRY: assert property (@(posedge clk) disable iff (!rst_n) op == 3'd1 |=> !flags_o[0]); // R2
  AST_SET_CARRY: assert property (@(posedge clk) disable iff (!rst_n) op == 3'd2 |=> flags_o[0]); // R2
  AST_INV_CARRY: assert property (@(posedge clk) disable iff (!rst_n) op == 3'd3 |=> flags_o[0] != $past(flags_o[0])); // R2
  AST_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n) op == 3'd4 |=> !flags_o[6]); // R3
  AST_IRQ_ON: assert property (@(posedge clk) disable iff (!rst_n) op == 3'd5 |=> flags_o[6]); // R3
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (op != 3'd4 && op != 3'd5) |=> $stable(flags_o[6])); // R3
  AST_BYTE_TRACKS: assert property (@(posedge clk) disable iff (!rst_n) status_byte[7] == flags_o[4] && status_byte[0] == flags_o[0]); // R4
  AST_LOAD_STILL: assert property (@(posedge clk) disable iff (!rst_n) (op == 3'd6 && alu_we == 6'd0) |=> $stable(flags_o)); // R5
  AST_STORE_LOW: assert property (@(posedge clk) disable iff (!rst_n) op == 3'd7 |=>
    flags_o[4:0] == {$past(byte_in[7]), $past(byte_in[6]), $past(byte_in[4]), $past(byte_in[2]), $past(byte_in[0])}); // R6
  AST_STORE_KEEP_OF: assert property (@(posedge clk) disable iff (!rst_n) (op == 3'd7 && !alu_we[5]) |=> $stable(flags_o[5])); // R6
  AST_OP_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n) (op == 3'd2 && alu_we[0] && !alu_flags[0]) |=> flags_o[0]); // R8
  AST_NOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (op == 3'd0 && alu_we == 6'd0) |=> $stable(flags_o)); // R9
endmodule

bind flag_reg flag_reg_chk chk_i (
  .clk(clk), .rst_n(rst_n), .op(op), .byte_in(byte_in), .alu_flags(alu_flags),
  .alu_we(alu_we), .flags_o(flags_o), .status_byte(status_byte)
);

// File: tb/flag_reg_tb_top.sv
`timescale 1ns/1ps
module flag_reg_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] op = '0;
  logic [7:0] byte_in = '0;
  logic [5:0] alu_flags = '0;
  logic [5:0] alu_we = '0;
  logic [6:0] flags_o;
  logic [7:0] status_byte;

  int n_run = 0, n_fail = 0;
  logic [6:0] exp_f;

  always #2 clk = ~clk;

  flag_reg dut_i (.clk(clk), .rst_n(rst_n), .op(op), .byte_in(byte_in),
                  .alu_flags(alu_flags), .alu_we(alu_we), .flags_o(flags_o),
                  .status_byte(status_byte));

  function automatic logic [7:0] pack(input logic [6:0] f);
    return {f[4], f[3], 1'b0, f[2], 1'b0, f[1], 1'b1, f[0]};
  endfunction

  task automatic check(input string req, input logic [6:0] e);
    n_run++;
    if (flags_o !== e || status_byte !== pack(e)) begin
      n_fail++;
      $display("FAIL %s flags=%b byte=%h expected flags=%b byte=%h",
               req, flags_o, status_byte, e, pack(e));
    end
  endtask

  task automatic step(input logic [2:0] o, input logic [7:0] b,
                      input logic [5:0] af, input logic [5:0] we);
    @(negedge clk);
    op = o; byte_in = b; alu_flags = af; alu_we = we;
    @(posedge clk);
    #1;
    op = 3'd0; alu_we = '0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    #1;
    exp_f = '0;
    check("R1 reset", exp_f);
    @(negedge clk); rst_n = 1'b1;
    step(3'd0, 8'h00, 6'h00, 6'h00);
    check("R1 after release", exp_f);
  endtask

  task automatic t_carry;
    step(3'd2, 8'h00, 6'h00, 6'h00); exp_f[0] = 1'b1; check("R2 set carry", exp_f);
    step(3'd3, 8'h00, 6'h00, 6'h00); exp_f[0] = 1'b0; check("R2 invert 1->0", exp_f);
    step(3'd3, 8'h00, 6'h00, 6'h00); exp_f[0] = 1'b1; check("R2 invert 0->1", exp_f);
    step(3'd1, 8'h00, 6'h00, 6'h00); exp_f[0] = 1'b0; check("R2 clear carry", exp_f);
  endtask

  task automatic t_irq;
    step(3'd5, 8'h00, 6'h00, 6'h00); exp_f[6] = 1'b1; check("R3 set IE", exp_f);
    step(3'd7, 8'hFF, 6'h00, 6'h00); exp_f[4:0] = 5'h1F; check("R3 R6 store keeps IE", exp_f);
    step(3'd4, 8'h00, 6'h00, 6'h00); exp_f[6] = 1'b0; check("R3 clear IE", exp_f);
  endtask

  task automatic t_alu;
    step(3'd0, 8'h00, 6'b101010, 6'b111111); exp_f[5:0] = 6'b101010; check("R7 R4 ALU all", exp_f);
    step(3'd0, 8'h00, 6'b010101, 6'b000110); exp_f[2] = 1'b1; exp_f[1] = 1'b0; check("R7 ALU partial", exp_f);
    step(3'd0, 8'h00, 6'h3F, 6'h00); check("R9 nop no enable", exp_f);
  endtask

  task automatic t_load;
    step(3'd6, 8'hA5, 6'h00, 6'h00); check("R5 load unchanged", exp_f);
  endtask

  task automatic t_store;
    step(3'd0, 8'h00, 6'b100000, 6'b100000); exp_f[5] = 1'b1;
    step(3'd5, 8'h00, 6'h00, 6'h00); exp_f[6] = 1'b1;
    step(3'd7, 8'h1E, 6'h00, 6'h00); exp_f[4:0] = 5'b00110; check("R6 store 0x1E", exp_f);
    step(3'd7, 8'h2A, 6'h00, 6'h00); exp_f[4:0] = 5'b00000; check("R6 unused bits ignored", exp_f);
    step(3'd7, 8'hD5, 6'h00, 6'h00); exp_f[4:0] = 5'b11111; check("R6 store 0xD5", exp_f);
  endtask

  task automatic t_priority;
    step(3'd1, 8'h00, 6'b000001, 6'b100001); exp_f[0] = 1'b0; exp_f[5] = 1'b0; check("R8 clear beats ALU", exp_f);
    step(3'd3, 8'h00, 6'b000000, 6'b000001); exp_f[0] = 1'b1; check("R8 invert beats ALU", exp_f);
    step(3'd7, 8'h00, 6'b111111, 6'b111111); exp_f[4:0] = 5'b00000; exp_f[5] = 1'b1; check("R8 store beats ALU, OF from ALU", exp_f);
    step(3'd4, 8'h00, 6'b011111, 6'b000011); exp_f[6] = 1'b0; exp_f[1:0] = 2'b11; check("R8 R3 ALU with IE op", exp_f);
  endtask

  initial begin
    t_reset();
    t_carry();
    t_irq();
    t_alu();
    t_load();
    t_store();
    t_priority();
    step(3'd0, 8'hFF, 6'h00, 6'h00); check("R9 nop", exp_f);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule